// File: doc/BRIEF.md
# Lowest-Sixteen Two-List Merge Network

This block is the last stage of a selection tree. It takes two lists of unsigned keys. Each list is already sorted ascending and holds N keys, with N = 16 by default. The block returns the N smallest keys of the combined 2N. Smaller sorters upstream each sort one slice of a wide input set, and this block keeps only the lower half of their combined output.

The selecting stage is one layer of N compare-and-exchange elements. Element i compares lane i of list A with lane N-1-i of list B and keeps the smaller key. The larger key is thrown away. This one layer gives the correct set of keys, but its output order is bitonic rather than ascending.

When the parameter ORDERED is 1, log2(N) more layers are built. Each layer has N/2 comparators and works on strides N/2 down to 1. Together they sort that bitonic set into ascending order. When the parameter PIPE is 1, one output register is added, and the valid flag is delayed by the same single cycle.

Top module: `low_half_merge`

## Requirements
- R1: For every valid input pair, the N output keys form the same multiset as the N smallest of the 2N input keys, whatever the setting of ORDERED.
- R2: With ORDERED=1, the output keys are ascending. Key k occupies bits [k*W +: W] of `low_keys`, so lane 0 holds the overall minimum and lane N-1 holds the N-th smallest key. The input lanes use the same layout, and each input list must be ascending from lane 0.
- R3: With ORDERED=0, output lane i equals the smaller of input lane i of list A and input lane N-1-i of list B.
- R4: Duplicate keys are kept. When several inputs share a value, each copy counts toward the N smallest, and none is merged or dropped.
- R5: With PIPE=0, `valid_out` equals `valid_in` in the same cycle, and `low_keys` reflects the current inputs with no clock edge involved.
- R6: With PIPE=1, `valid_out` is `valid_in` delayed by one clock. `low_keys` loads on a rising edge where `valid_in` is 1 and keeps its value on every other edge.
- R7: With PIPE=1, an active-low `rst_n` clears `valid_out` and `low_keys` to 0 at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_in | input | 1 | The two input lists hold a valid pair |
| a_keys | input | N*W | First ascending list, lane i at bits [i*W +: W] |
| b_keys | input | N*W | Second ascending list, same lane layout |
| valid_out | output | 1 | `low_keys` holds a valid result |
| low_keys | output | N*W | The N smallest keys, lane k at bits [k*W +: W] |

## Verification
The two lists are tried in several arrangements:
- All of list A lies below all of list B, or the reverse. This shows whether the lane pairing that crosses the two lists is wired correctly.
- The two lists interleave, or overlap only partly. This exercises the selecting layer at every crossover point and exercises every stride of the ordering layers.
- All keys are equal, or one list is a run of a single value sitting among distinct keys. This separates correct duplicate handling from a network that loses copies.
- Keys sit at the top of the range, which exposes comparison errors at the full width.

An ordered, registered instance and an unordered, combinational instance run side by side. One shows the exact lane pattern of the selecting layer, and the other shows the final ascending order and the register's load, hold and reset behaviour.

// File: rtl/lhm_pkg.sv
package lhm_pkg;

  // Strobes from control to datapath.
  typedef struct packed {
    logic capture;   // load the output register on this edge
  } lhm_strobe_t;

endpackage

// File: rtl/lhm_select.sv
// One layer of compare-and-exchange elements that keeps the lower half
// of the union of two ascending lists. The larger output of each
// element is discarded. The result is bitonic.
module lhm_select #(
  parameter int N = 16,
  parameter int W = 16
) (
  input  logic [N-1:0][W-1:0] aList,
  input  logic [N-1:0][W-1:0] bList,
  output logic [N-1:0][W-1:0] selList
);

  for (genvar i = 0; i < N; i++) begin : g_cmp
    logic aWins;
    assign aWins      = aList[i] <= bList[N-1-i];
    assign selList[i] = aWins ? aList[i] : bList[N-1-i];
  end

endmodule

// File: rtl/lhm_order.sv
// Optional bitonic merger: log2(N) half-cleaner layers, strides N/2 .. 1.
module lhm_order #(
  parameter int N       = 16,
  parameter int W       = 16,
  parameter bit ORDERED = 1
) (
  input  logic [N-1:0][W-1:0] bitonicList,
  output logic [N-1:0][W-1:0] sortedList
);

  localparam int STAGES = $clog2(N);

  if (ORDERED) begin : g_merge
    logic [N-1:0][W-1:0] stg [STAGES+1];
    assign stg[0] = bitonicList;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      localparam int STRIDE = N >> (s + 1);
      for (genvar j = 0; j < N; j++) begin : g_lane
        if ((j & STRIDE) == 0) begin : g_pair
          logic lowFirst;
          assign lowFirst = stg[s][j] <= stg[s][j+STRIDE];
          assign stg[s+1][j]        = lowFirst ? stg[s][j]        : stg[s][j+STRIDE];
          assign stg[s+1][j+STRIDE] = lowFirst ? stg[s][j+STRIDE] : stg[s][j];
        end
      end
    end

    assign sortedList = stg[STAGES];
  end else begin : g_pass
    assign sortedList = bitonicList;
  end

endmodule

// File: rtl/lhm_ctrl.sv
// Valid tracking and capture strobe for the optional output register.
module lhm_ctrl #(
  parameter bit PIPE = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 valid_in,
  output lhm_pkg::lhm_strobe_t strobe,
  output logic                 valid_out
);

  assign strobe.capture = valid_in;

  if (PIPE) begin : g_reg
    logic validQ;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) validQ <= 1'b0;
      else        validQ <= valid_in;
    end
    assign valid_out = validQ;
  end else begin : g_comb
    assign valid_out = valid_in;
  end

endmodule

// File: rtl/lhm_dp.sv
// Datapath: selecting layer, optional ordering layers, optional register.
module lhm_dp #(
  parameter int N       = 16,
  parameter int W       = 16,
  parameter bit ORDERED = 1,
  parameter bit PIPE    = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  lhm_pkg::lhm_strobe_t strobe,
  input  logic [N-1:0][W-1:0]  aList,
  input  logic [N-1:0][W-1:0]  bList,
  output logic [N-1:0][W-1:0]  lowList
);

  logic [N-1:0][W-1:0] selList;
  logic [N-1:0][W-1:0] sortedList;

  lhm_select #(.N(N), .W(W)) u_select (
    .aList   (aList),
    .bList   (bList),
    .selList (selList)
  );

  lhm_order #(.N(N), .W(W), .ORDERED(ORDERED)) u_order (
    .bitonicList (selList),
    .sortedList  (sortedList)
  );

  if (PIPE) begin : g_reg
    logic [N-1:0][W-1:0] lowQ;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              lowQ <= '0;
      else if (strobe.capture) lowQ <= sortedList;
    end
    assign lowList = lowQ;
  end else begin : g_comb
    assign lowList = sortedList;
  end

endmodule

// File: rtl/low_half_merge.sv
// Top: keeps the N smallest keys of two ascending N-key lists.
// N must be a power of two, at least 2.
module low_half_merge #(
  parameter int N       = 16,
  parameter int W       = 16,
  parameter bit ORDERED = 1,
  parameter bit PIPE    = 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           valid_in,
  input  logic [N*W-1:0] a_keys,
  input  logic [N*W-1:0] b_keys,
  output logic           valid_out,
  output logic [N*W-1:0] low_keys
);

  lhm_pkg::lhm_strobe_t strobe;
  logic [N-1:0][W-1:0]  aList;
  logic [N-1:0][W-1:0]  bList;
  logic [N-1:0][W-1:0]  lowList;

  assign aList    = a_keys;
  assign bList    = b_keys;
  assign low_keys = lowList;

  lhm_ctrl #(.PIPE(PIPE)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_in  (valid_in),
    .strobe    (strobe),
    .valid_out (valid_out)
  );

  lhm_dp #(.N(N), .W(W), .ORDERED(ORDERED), .PIPE(PIPE)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (strobe),
    .aList   (aList),
    .bList   (bList),
    .lowList (lowList)
  );

endmodule

// File: rtl/low_half_merge_chk.sv
// Property checker, bound to every instance of the top module.
module low_half_merge_chk #(
  parameter int N       = 16,
  parameter int W       = 16,
  parameter bit ORDERED = 1,
  parameter bit PIPE    = 1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           valid_in,
  input logic [N*W-1:0] a_keys,
  input logic [N*W-1:0] b_keys,
  input logic           valid_out,
  input logic [N*W-1:0] low_keys
);

  logic         primed;
  logic [W-1:0] headMin;
  logic [W-1:0] headMinQ;
  logic         ascending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;
  end

  assign headMin = (a_keys[W-1:0] <= b_keys[W-1:0]) ? a_keys[W-1:0] : b_keys[W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        headMinQ <= '0;
    else if (valid_in) headMinQ <= headMin;
  end

  always_comb begin
    ascending = 1'b1;
    for (int k = 0; k < N - 1; k++) begin
      if (low_keys[k*W +: W] > low_keys[(k+1)*W +: W]) ascending = 1'b0;
    end
  end

  // R1: the smallest output lane is the smaller of the two list heads
  assert_head_min_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ORDERED && valid_out && (!PIPE || primed)) |->
      (low_keys[W-1:0] == (PIPE ? headMinQ : headMin)));

  // R2: ordered output is ascending
  assert_ascending_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ORDERED && valid_out) |-> ascending);

  // R5: no latency on the valid flag without the register
  assert_valid_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !PIPE |-> (valid_out == valid_in));

  // R6: one-cycle valid latency with the register
  assert_valid_delay_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (PIPE && primed) |-> (valid_out == $past(valid_in)));

  // R6: the register holds when nothing valid arrived
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (PIPE && primed && !$past(valid_in)) |-> $stable(low_keys));

endmodule

bind low_half_merge low_half_merge_chk #(
  .N(N), .W(W), .ORDERED(ORDERED), .PIPE(PIPE)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .valid_in  (valid_in),
  .a_keys    (a_keys),
  .b_keys    (b_keys),
  .valid_out (valid_out),
  .low_keys  (low_keys)
);

// File: tb/low_half_merge_bench.sv
module low_half_merge_bench;

  localparam int N = 16;
  localparam int W = 16;

  typedef logic [N-1:0][W-1:0] list_t;

  typedef struct packed {
    logic [W-1:0] aBase;
    logic [W-1:0] aStep;
    logic [W-1:0] bBase;
    logic [W-1:0] bStep;
    logic [W-1:0] expMin;
    logic [W-1:0] expMax;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{16'd0,     16'd1, 16'd100,   16'd1, 16'd0,     16'd15},
    '{16'd100,   16'd1, 16'd0,     16'd2, 16'd0,     16'd30},
    '{16'd0,     16'd2, 16'd1,     16'd2, 16'd0,     16'd15},
    '{16'd7,     16'd0, 16'd7,     16'd0, 16'd7,     16'd7},
    '{16'd10,    16'd3, 16'd20,    16'd1, 16'd10,    16'd28},
    '{16'd65535, 16'd0, 16'd65520, 16'd1, 16'd65520, 16'd65535},
    '{16'd5,     16'd0, 16'd0,     16'd1, 16'd0,     16'd5}
  };

  logic           clk = 1'b0;
  logic           rst_n = 1'b1;
  logic           valid_in = 1'b0;
  list_t          aArr = '0;
  list_t          bArr = '0;
  logic           validP, validR;
  logic [N*W-1:0] outP, outR;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  low_half_merge #(.N(N), .W(W), .ORDERED(1), .PIPE(1)) u_low_half_merge (
    .clk(clk), .rst_n(rst_n), .valid_in(valid_in),
    .a_keys(aArr), .b_keys(bArr), .valid_out(validP), .low_keys(outP)
  );

  low_half_merge #(.N(N), .W(W), .ORDERED(0), .PIPE(0)) u_low_half_merge_raw (
    .clk(clk), .rst_n(rst_n), .valid_in(valid_in),
    .a_keys(aArr), .b_keys(bArr), .valid_out(validR), .low_keys(outR)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [N*W-1:0] act, input logic [N*W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Expected lower half, by a two-pointer merge.
  function automatic list_t refLow(input list_t a, input list_t b);
    list_t r;
    int ia = 0;
    int ib = 0;
    for (int k = 0; k < N; k++) begin
      if (ib >= N || (ia < N && a[ia] <= b[ib])) begin r[k] = a[ia]; ia++; end
      else begin r[k] = b[ib]; ib++; end
    end
    return r;
  endfunction

  function automatic list_t sortList(input list_t x);
    list_t r = x;
    for (int i = 1; i < N; i++) begin
      for (int j = i; j > 0; j--) begin
        if (r[j-1] > r[j]) begin
          logic [W-1:0] t = r[j];
          r[j] = r[j-1];
          r[j-1] = t;
        end
      end
    end
    return r;
  endfunction

  function automatic list_t rawExpect(input list_t a, input list_t b);
    list_t r;
    for (int i = 0; i < N; i++) r[i] = (a[i] <= b[N-1-i]) ? a[i] : b[N-1-i];
    return r;
  endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    #(8 * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    list_t exp;
    list_t held;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(validP == 1'b0, "R7 reset valid_out", {255'd0, validP}, '0);
    check(outP == '0, "R7 reset low_keys", outP, '0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      for (int i = 0; i < N; i++) begin
        aArr[i] = VECS[v].aBase + VECS[v].aStep * W'(i);
        bArr[i] = VECS[v].bBase + VECS[v].bStep * W'(i);
      end
      valid_in = 1'b1;
      exp = refLow(aArr, bArr);
      #1;
      check(validR == 1'b1, "R5 comb valid", {255'd0, validR}, {255'd0, 1'b1});
      check(outR == rawExpect(aArr, bArr), "R3 raw lane pattern", outR, rawExpect(aArr, bArr));
      check(sortList(outR) == exp, "R1/R4 raw multiset", sortList(outR), exp);
      @(negedge clk);
      check(validP == 1'b1, "R6 piped valid", {255'd0, validP}, {255'd0, 1'b1});
      check(outP == exp, "R2/R4 ordered result", outP, exp);
      check(outP[W-1:0] == VECS[v].expMin, "R1 minimum lane", {240'd0, outP[W-1:0]},
            {240'd0, VECS[v].expMin});
      check(outP[(N-1)*W +: W] == VECS[v].expMax, "R2 top lane", {240'd0, outP[(N-1)*W +: W]},
            {240'd0, VECS[v].expMax});
    end

    // R6: hold while valid_in is low, even with new inputs
    held = outP;
    valid_in = 1'b0;
    for (int i = 0; i < N; i++) begin aArr[i] = W'(i); bArr[i] = W'(i); end
    #1;
    check(validR == 1'b0, "R5 comb valid low", {255'd0, validR}, '0);
    @(negedge clk);
    check(validP == 1'b0, "R6 valid drops", {255'd0, validP}, '0);
    check(outP == held, "R6 hold keys", outP, held);
    @(negedge clk);
    check(outP == held, "R6 hold second cycle", outP, held);

    // R6: one-cycle latency from a fresh valid
    valid_in = 1'b1;
    exp = refLow(aArr, bArr);
    #1;
    check(validP == 1'b0, "R6 not before edge", {255'd0, validP}, '0);
    check(outP == held, "R6 keys not before edge", outP, held);
    @(negedge clk);
    check(validP == 1'b1, "R6 valid after edge", {255'd0, validP}, {255'd0, 1'b1});
    check(outP == exp, "R2/R4 equal-pairs result", outP, exp);

    // R7: asynchronous reset mid-run
    #1 rst_n = 1'b0;
    #1;
    check(validP == 1'b0, "R7 async valid clear", {255'd0, validP}, '0);
    check(outP == '0, "R7 async keys clear", outP, '0);
    valid_in = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(validP == 1'b0, "R7 stays clear", {255'd0, validP}, '0);

    summary();
    $finish;
  end

endmodule